// File: doc/BRIEF.md
# Interrupt Status-Word Swap Controller

This block holds the 128-bit program status word of a processor. It also performs the swap that hands control to an interruption handler. Six interruption classes each raise a level request line. When the controller is idle it picks one pending class by fixed priority. In the next cycle it saves the live status word into that class's old-word slot in a small internal slot memory. In the cycle after that it loads the class's new word, which software must have placed earlier in the class's new-word slot. A one-cycle `taken_o` pulse, carrying the class code, marks the cycle in which the new word first appears on `psw_o`.

Software prepares the new words through a valid/ready write port into the slot memory. A valid/ready load-status command copies any slot into the status word in one cycle. Loading the old-word slot of a class resumes the program that this class interrupted. Outside a swap, the instruction-address field (the low 64 bits of the word) moves forward by a step length for sequential execution, or is replaced by a branch target.

The write port accepts a beat when `wr_valid_i` and `wr_ready_o` are both high on a clock edge. The load-status port accepts a beat when `ld_valid_i` and `ld_ready_o` are both high on a clock edge. A master may hold valid high for as long as it likes while ready is low. Nothing is lost, and the beat is taken in the first cycle that ready is high. `wr_ready_o` is low during the two swap cycles. `ld_ready_o` is also low in any idle cycle where a request line is high, so that interruptions go ahead of resumption.

Top module: `psw_swap_ctrl`

## Requirements
- R1: After reset, `psw_o` is zero, `taken_o` is low, and all twelve slots read as zero through load-status.
- R2: Class codes are restart=0, supervisor-call=1, external=2, I/O=3, machine-check=4 and program=5. When several lines are high together, the winner is chosen in this order, highest first: machine-check, program, supervisor-call, external, I/O, restart.
- R3: Suppose a request line is high in cycle n while the block is idle. Then in cycle n+3 the following hold: `psw_o` equals the winner's new-word slot, `taken_o` is high for exactly that one cycle, and `taken_cls_o` gives the winner's code.
- R4: The old-word slot of class c is at address c, and its new-word slot is at address 6+c. During a swap, the old-word slot receives the status word as it stood in cycle n+1.
- R5: Request lines are not sampled in cycles n+1 and n+2. If a higher-priority request arrives during a swap, the swap in progress still completes with its original class. The new request is served by the next swap.
- R6: A load-status beat accepted in cycle m makes `psw_o` equal to the addressed slot in cycle m+1.
- R7: `wr_ready_o` is low in cycles n+1 and n+2 and high when idle. `ld_ready_o` is high only when the block is idle and no request line is high.
- R8: In an idle cycle with a step and no branch or load-status, bits 63:0 of the word increase by `step_len_i`, modulo 2^64, and bits 127:64 are unchanged.
- R9: In an idle cycle with a branch and no load-status, bits 63:0 take `branch_addr_i`, even when a step is also present.
- R10: Step and branch inputs have no effect in cycles n+1 and n+2.
- R11: A write beat stores `wr_data_i` into slot `wr_addr_i`.
- R12: Running a load-status from a class's old-word slot after its swap restores exactly the word that was interrupted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 6 | Level request per class, indexed by class code |
| step_valid_i | input | 1 | Advance the instruction address sequentially |
| step_len_i | input | 4 | Byte length of the sequential advance |
| branch_valid_i | input | 1 | Replace the instruction address |
| branch_addr_i | input | 64 | Branch target address |
| wr_valid_i | input | 1 | Slot write beat valid |
| wr_ready_o | output | 1 | Slot write port ready |
| wr_addr_i | input | 4 | Slot address of the write |
| wr_data_i | input | 128 | Word to store |
| ld_valid_i | input | 1 | Load-status command valid |
| ld_ready_o | output | 1 | Load-status port ready |
| ld_addr_i | input | 4 | Slot to load into the status word |
| psw_o | output | 128 | Current status word |
| taken_o | output | 1 | One-cycle pulse: interruption taken |
| taken_cls_o | output | 3 | Class code of the taken interruption |

## Verification
The step and branch properties assume that the step, branch and load-status inputs are known and steady around each rising edge. The stimulus drives every input one nanosecond after a rising edge. The bench never sends a write and a load-status to the same slot in one cycle, because the load would then return the value from before the write. Requesters drop their lines once a request is accepted, or, for the late-arrival case, once the pulse for the earlier class appears. This makes every accepted request in the sweep map to exactly one expected swap.

// File: rtl/psw_swap_pkg.sv
package psw_swap_pkg;
  localparam int NCLASS  = 6;
  localparam int NSLOT   = 2 * NCLASS;
  localparam int CLS_W   = $clog2(NCLASS);
  localparam int SLOT_AW = $clog2(NSLOT);

  typedef enum logic [CLS_W-1:0] {
    CLS_RESTART = 3'd0,
    CLS_SVC     = 3'd1,
    CLS_EXT     = 3'd2,
    CLS_IO      = 3'd3,
    CLS_MCHK    = 3'd4,
    CLS_PROG    = 3'd5
  } irq_cls_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_STORE = 2'd1,
    ST_LOAD  = 2'd2
  } swap_state_e;

  // rank 0 is served first
  function automatic int rank_to_cls(input int rank);
    case (rank)
      0:       return int'(CLS_MCHK);
      1:       return int'(CLS_PROG);
      2:       return int'(CLS_SVC);
      3:       return int'(CLS_EXT);
      4:       return int'(CLS_IO);
      default: return int'(CLS_RESTART);
    endcase
  endfunction
endpackage

// File: rtl/psw_prio_arb.sv
module psw_prio_arb
  import psw_swap_pkg::*;
(
  input  logic [NCLASS-1:0] req_i,
  output logic              any_o,
  output logic [CLS_W-1:0]  win_o
);
  always_comb begin
    any_o = |req_i;
    win_o = '0;
    // walk from lowest rank up so the highest-ranked pending class wins
    for (int r = NCLASS - 1; r >= 0; r--) begin
      if (req_i[rank_to_cls(r)]) win_o = CLS_W'(rank_to_cls(r));
    end
  end
endmodule

// File: rtl/psw_slot_mem.sv
module psw_slot_mem #(
  parameter int WORD_W = 128,
  parameter int DEPTH  = 12,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [DEPTH*WORD_W-1:0] flat;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [WORD_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                            q <= '0;
      else if (we_i && (waddr_i == AW'(i)))  q <= wdata_i;
    end
    assign flat[i*WORD_W +: WORD_W] = q;
  end

  always_comb begin
    if (int'(raddr_i) < DEPTH) rdata_o = flat[int'(raddr_i)*WORD_W +: WORD_W];
    else                       rdata_o = '0;
  end
endmodule

// File: rtl/psw_swap_fsm.sv
module psw_swap_fsm
  import psw_swap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_any_i,
  input  logic [CLS_W-1:0] win_i,
  output logic             idle_o,
  output logic             store_o,
  output logic             load_o,
  output logic [CLS_W-1:0] cls_o,
  output logic             taken_o,
  output logic [CLS_W-1:0] taken_cls_o
);
  swap_state_e state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      cls_o       <= '0;
      taken_o     <= 1'b0;
      taken_cls_o <= '0;
    end else begin
      taken_o <= 1'b0;
      case (state)
        ST_IDLE: if (req_any_i) begin
          cls_o <= win_i;
          state <= ST_STORE;
        end
        ST_STORE: state <= ST_LOAD;
        ST_LOAD: begin
          state       <= ST_IDLE;
          taken_o     <= 1'b1;
          taken_cls_o <= cls_o;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign idle_o  = (state == ST_IDLE);
  assign store_o = (state == ST_STORE);
  assign load_o  = (state == ST_LOAD);
endmodule

// File: rtl/psw_swap_ctrl.sv
module psw_swap_ctrl
  import psw_swap_pkg::*;
#(
  parameter int WORD_W = 128,
  parameter int IA_W   = 64,
  parameter int STEP_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NCLASS-1:0]  req_i,
  input  logic               step_valid_i,
  input  logic [STEP_W-1:0]  step_len_i,
  input  logic               branch_valid_i,
  input  logic [IA_W-1:0]    branch_addr_i,
  input  logic               wr_valid_i,
  output logic               wr_ready_o,
  input  logic [SLOT_AW-1:0] wr_addr_i,
  input  logic [WORD_W-1:0]  wr_data_i,
  input  logic               ld_valid_i,
  output logic               ld_ready_o,
  input  logic [SLOT_AW-1:0] ld_addr_i,
  output logic [WORD_W-1:0]  psw_o,
  output logic               taken_o,
  output logic [CLS_W-1:0]   taken_cls_o
);
  localparam int HI_W = WORD_W - IA_W;

  logic              req_any, idle, store_en, load_en;
  logic [CLS_W-1:0]  win, cls_q;
  logic              mem_we;
  logic [SLOT_AW-1:0] mem_waddr, mem_raddr;
  logic [WORD_W-1:0] mem_wdata, mem_rdata;
  logic              ld_fire, wr_fire;
  logic [WORD_W-1:0] psw_q;

  psw_prio_arb u_arb (
    .req_i (req_i),
    .any_o (req_any),
    .win_o (win)
  );

  psw_swap_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_any_i   (req_any),
    .win_i       (win),
    .idle_o      (idle),
    .store_o     (store_en),
    .load_o      (load_en),
    .cls_o       (cls_q),
    .taken_o     (taken_o),
    .taken_cls_o (taken_cls_o)
  );

  assign wr_ready_o = idle;
  assign ld_ready_o = idle && !req_any;
  assign wr_fire    = wr_valid_i && wr_ready_o;
  assign ld_fire    = ld_valid_i && ld_ready_o;

  // the single write port is shared between the swap store and the host
  assign mem_we    = store_en || wr_fire;
  assign mem_waddr = store_en ? SLOT_AW'(cls_q) : wr_addr_i;
  assign mem_wdata = store_en ? psw_q : wr_data_i;
  assign mem_raddr = load_en ? SLOT_AW'(NCLASS) + SLOT_AW'(cls_q) : ld_addr_i;

  psw_slot_mem #(
    .WORD_W (WORD_W),
    .DEPTH  (NSLOT),
    .AW     (SLOT_AW)
  ) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (mem_we),
    .waddr_i (mem_waddr),
    .wdata_i (mem_wdata),
    .raddr_i (mem_raddr),
    .rdata_o (mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psw_q <= '0;
    end else if (load_en) begin
      psw_q <= mem_rdata;
    end else if (idle) begin
      if (ld_fire)             psw_q <= mem_rdata;
      else if (branch_valid_i) psw_q <= {psw_q[WORD_W-1 -: HI_W], branch_addr_i};
      else if (step_valid_i)   psw_q <= {psw_q[WORD_W-1 -: HI_W],
                                         psw_q[IA_W-1:0] + IA_W'(step_len_i)};
    end
  end

  assign psw_o = psw_q;
endmodule

// File: rtl/psw_swap_ctrl_chk.sv
module psw_swap_ctrl_chk
  import psw_swap_pkg::*;
#(
  parameter int WORD_W = 128,
  parameter int IA_W   = 64,
  parameter int STEP_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              step_valid_i,
  input logic [STEP_W-1:0] step_len_i,
  input logic              branch_valid_i,
  input logic [IA_W-1:0]   branch_addr_i,
  input logic              wr_ready_o,
  input logic              ld_valid_i,
  input logic              ld_ready_o,
  input logic [WORD_W-1:0] psw_o,
  input logic              taken_o,
  input logic [CLS_W-1:0]  taken_cls_o
);
  assert_taken_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |=> !taken_o);

  assert_taken_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |-> (int'(taken_cls_o) < NCLASS));

  assert_swap_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |-> $past(!wr_ready_o));

  assert_frozen_in_swap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ready_o && $past(!wr_ready_o)) |-> $stable(psw_o));

  assert_load_no_swap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid_i && ld_ready_o) |=> !taken_o);

  assert_branch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (branch_valid_i && wr_ready_o && !(ld_valid_i && ld_ready_o))
      |=> (psw_o[IA_W-1:0] == $past(branch_addr_i)));

  assert_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid_i && !branch_valid_i && wr_ready_o && !(ld_valid_i && ld_ready_o))
      |=> (psw_o[IA_W-1:0] == $past(psw_o[IA_W-1:0]) + IA_W'($past(step_len_i))));
endmodule

bind psw_swap_ctrl psw_swap_ctrl_chk #(
  .WORD_W (WORD_W),
  .IA_W   (IA_W),
  .STEP_W (STEP_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .step_valid_i   (step_valid_i),
  .step_len_i     (step_len_i),
  .branch_valid_i (branch_valid_i),
  .branch_addr_i  (branch_addr_i),
  .wr_ready_o     (wr_ready_o),
  .ld_valid_i     (ld_valid_i),
  .ld_ready_o     (ld_ready_o),
  .psw_o          (psw_o),
  .taken_o        (taken_o),
  .taken_cls_o    (taken_cls_o)
);

// File: tb/psw_swap_ctrl_tb.sv
module psw_swap_ctrl_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [5:0]   req = '0;
  logic         step_valid = 1'b0;
  logic [3:0]   step_len = '0;
  logic         branch_valid = 1'b0;
  logic [63:0]  branch_addr = '0;
  logic         wr_valid = 1'b0;
  logic         wr_ready;
  logic [3:0]   wr_addr = '0;
  logic [127:0] wr_data = '0;
  logic         ld_valid = 1'b0;
  logic         ld_ready;
  logic [3:0]   ld_addr = '0;
  logic [127:0] psw;
  logic         taken;
  logic [2:0]   taken_cls;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [127:0] pre;
  int win;

  always #2.5 clk = ~clk;

  psw_swap_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req),
    .step_valid_i(step_valid), .step_len_i(step_len),
    .branch_valid_i(branch_valid), .branch_addr_i(branch_addr),
    .wr_valid_i(wr_valid), .wr_ready_o(wr_ready), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .ld_valid_i(ld_valid), .ld_ready_o(ld_ready), .ld_addr_i(ld_addr),
    .psw_o(psw), .taken_o(taken), .taken_cls_o(taken_cls)
  );

  function automatic logic [127:0] new_word(input int c);
    return {32'hC0DE_0000 | 32'(c), 32'h5A5A_0000 + 32'(c * 3),
            64'h0000_0000_0010_0000 + 64'(c) * 64'h1000};
  endfunction

  function automatic int exp_winner(input logic [5:0] m);
    int order [6] = '{4, 5, 1, 2, 3, 0};
    for (int r = 0; r < 6; r++) if (m[order[r]]) return order[r];
    return 0;
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic load_slot(input int s);
    ld_valid = 1'b1;
    ld_addr  = 4'(s);
    tick();
    ld_valid = 1'b0;
    #1;
  endtask

  task automatic write_slot(input int s, input logic [127:0] d);
    wr_valid = 1'b1;
    wr_addr  = 4'(s);
    wr_data  = d;
    tick();
    wr_valid = 1'b0;
  endtask

  task automatic do_branch(input logic [63:0] a);
    branch_valid = 1'b1;
    branch_addr  = a;
    tick();
    branch_valid = 1'b0;
    #1;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=hung exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    #1;
    // R1: reset state
    check("R1 psw after reset", psw, '0);
    check("R1 taken after reset", 128'(taken), '0);
    for (int s = 0; s < 12; s++) begin
      load_slot(s);
      check("R1 slot zero", psw, '0);
    end

    // R11: preload new words, read back
    for (int c = 0; c < 6; c++) write_slot(6 + c, new_word(c));
    for (int c = 0; c < 6; c++) begin
      load_slot(6 + c);
      check("R11 new word readback", psw, new_word(c));
      check("R6 load-status latency", psw, new_word(c));
    end

    // R9 / R8: branch, step and wrap
    pre = psw;
    do_branch(64'hFFFF_FFFF_FFFF_FFFD);
    check("R9 branch", psw, {pre[127:64], 64'hFFFF_FFFF_FFFF_FFFD});
    step_valid = 1'b1; step_len = 4'd5;
    tick(); step_valid = 1'b0; #1;
    check("R8 step wraps", psw, {pre[127:64], 64'h2});
    step_valid = 1'b1; step_len = 4'd15;
    tick(); tick(); step_valid = 1'b0; #1;
    check("R8 repeated step", psw, {pre[127:64], 64'd32});
    step_valid = 1'b1; step_len = 4'd6; branch_valid = 1'b1; branch_addr = 64'h4000;
    tick(); step_valid = 1'b0; branch_valid = 1'b0; #1;
    check("R9 branch beats step", psw, {pre[127:64], 64'h4000});

    // R2 R3 R4 R7 R12: sweep of every request pattern
    for (int m = 1; m < 64; m++) begin
      do_branch(64'(m) * 64'h10 + 64'h8);
      pre = psw;
      win = exp_winner(6'(m));
      req = 6'(m);
      #1;
      check("R7 ld_ready low with request", 128'(ld_ready), '0);
      tick();                     // cycle n+1
      req = '0;
      #1;
      check("R7 wr_ready low in swap", 128'(wr_ready), '0);
      check("R3 no early taken", 128'(taken), '0);
      tick();                     // n+2
      tick();                     // n+3
      check("R3 taken pulse", 128'(taken), 128'd1);
      check("R2 winner code", 128'(taken_cls), 128'(win));
      check("R3 new word loaded", psw, new_word(win));
      tick();                     // n+4
      check("R3 pulse one cycle", 128'(taken), '0);
      check("R7 ready when idle", 128'({wr_ready, ld_ready}), 128'd3);
      load_slot(win);
      check("R4 R12 old word restored", psw, pre);
    end

    // R10: step and branch ignored in swap cycles
    do_branch(64'h7770);
    pre = psw;
    req = 6'b001000;
    tick();
    req = '0; step_valid = 1'b1; step_len = 4'd4; branch_valid = 1'b1; branch_addr = 64'h1234;
    tick();
    tick();
    step_valid = 1'b0; branch_valid = 1'b0;
    check("R10 new word untouched", psw, new_word(3));
    tick();
    load_slot(3);
    check("R10 old word untouched", psw, pre);

    // R5: late higher-priority request waits for the current swap
    do_branch(64'h9990);
    pre = psw;
    req = 6'b000001;
    tick();
    req = 6'b010001;
    tick();
    tick();
    req = 6'b010000;
    check("R5 first swap keeps class", 128'(taken_cls), 128'd0);
    check("R5 first swap word", psw, new_word(0));
    tick();
    req = '0;
    tick();
    tick();
    check("R5 second swap taken", 128'(taken), 128'd1);
    check("R5 second swap class", 128'(taken_cls), 128'd4);
    check("R5 second swap word", psw, new_word(4));
    tick();
    load_slot(0);
    check("R5 restart old word", psw, pre);
    load_slot(4);
    check("R5 mcheck old word", psw, new_word(0));

    done = 1'b1;
    summary();
    $finish;
  end
endmodule